// File: doc/BRIEF.md
# Rejection-Sampling Range Limiter

This block turns raw random words, assumed uniform over the full word range, into uniform integers from zero up to an inclusive bound chosen per request. A request strobe captures the bound. From it the block works out a scale factor: the largest raw value integer-divided by (bound + 1). Each raw word is then divided by that factor. A quotient above the bound is thrown away and the block asks its source for another word. The first quotient inside the range becomes the result.

Out-of-range quotients are redrawn rather than folded back with a modulo, so no result value is favoured. The cost is a latency per result that depends on how many words were discarded. A single shift-subtract divider, which retires one quotient bit per clock, serves both the scale computation and every candidate. The upstream source connects through a valid/ready pair. The result leaves through a second valid/ready pair. A counter of discarded words for the current request is exposed for checking.

Top module: `rng_range_limiter`

## Requirements
- R1: Every emitted result lies between 0 and the bound captured for that request, both ends included.
- R2: The scale factor is floor(RAW_MAX / (bound + 1)), with RAW_MAX = 2^RAW_W - 1. It is computed once per request. Each candidate is floor(raw / scale).
- R3: A candidate greater than the bound is discarded and one fresh raw word is consumed. This repeats until a candidate is within range, and only then is a result emitted. Each discard raises reject_cnt_o by one, saturating at its all-ones value.
- R4: A bound of 0 gives a result of 0 with res_valid_o high on the clock after the accepted start. No raw word is consumed.
- R5: A bound equal to RAW_MAX uses a scale of 1, so the result equals the first raw word offered, with no discards.
- R6: Once res_valid_o is high, it stays high with res_data_o unchanged until a cycle where res_ready_i is high. The next cycle it is low.
- R7: raw_ready_o is high only while the block waits for a raw word, never while a result is pending. Exactly one word is taken per valid/ready handshake.
- R8: A start strobe is accepted only while the block is idle. A strobe during a request changes neither the captured bound nor the result.
- R9: reject_cnt_o returns to 0 at each accepted start. While the result is offered, it equals the number of words discarded for that request.
- R10: After reset, res_valid_o, raw_ready_o and reject_cnt_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, taken when idle |
| limit_i | input | RAW_W | Inclusive upper bound, captured with start |
| raw_valid_i | input | 1 | Raw word available |
| raw_data_i | input | RAW_W | Raw random word |
| raw_ready_o | output | 1 | Block takes a raw word this cycle |
| res_valid_o | output | 1 | Bounded result offered |
| res_data_o | output | RAW_W | Bounded result |
| res_ready_i | input | 1 | Consumer accepts the result |
| reject_cnt_o | output | REJ_W | Words discarded in the current request |

## Verification
On every cycle the assertions check several properties. The offered result never exceeds the captured bound. A stalled result holds its value. A word source is never asked while a result is pending. Each discard advances the counter. Each start clears it. A zero bound produces zero on the next clock. A strobe during a request leaves the bound alone. Whether the value is the correct quotient of the correct word is only visible in the bench scenarios. There, the bench recomputes the scale, walks the same word list, and predicts the result, the number of discards and the number of words taken. It does this across forced-rejection runs, bounds at 0, 1, RAW_MAX-1 and RAW_MAX, a stalled source and a stalled consumer.

// File: rtl/rrl_pkg.sv
package rrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SCALE = 3'd1,
    ST_FETCH = 3'd2,
    ST_DIV   = 3'd3,
    ST_OFFER = 3'd4
  } rrl_state_e;

endpackage

// File: rtl/rrl_seq_div.sv
// Restoring shift-subtract divider: one quotient bit per clock, DVD_W steps.
module rrl_seq_div #(
  parameter int DVD_W = 16,
  parameter int DVS_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DVS_W-1:0] divisor,
  output logic             done,
  output logic [DVD_W-1:0] quotient
);
  localparam int CNT_W = $clog2(DVD_W + 1);

  logic [DVS_W-1:0] rem_q;
  logic [DVS_W-1:0] dvs_q;
  logic [DVD_W-1:0] shf_q;
  logic [DVD_W-1:0] quo_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  logic [DVS_W:0]   trial;
  logic [DVS_W:0]   diff;
  logic             fits;

  assign trial = {rem_q, shf_q[DVD_W-1]};
  assign fits  = (trial >= {1'b0, dvs_q});
  assign diff  = trial - {1'b0, dvs_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      dvs_q <= '0;
      shf_q <= '0;
      quo_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        rem_q <= '0;
        dvs_q <= divisor;
        shf_q <= dividend;
        quo_q <= '0;
        cnt_q <= CNT_W'(DVD_W);
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= fits ? DVS_W'(diff) : DVS_W'(trial);
        shf_q <= {shf_q[DVD_W-2:0], 1'b0};
        quo_q <= {quo_q[DVD_W-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          run_q <= 1'b0;
          done  <= 1'b1;
        end
      end
    end
  end

  assign quotient = quo_q;
endmodule

// File: rtl/rrl_out_hold.sv
// Result register: holds valid and data until the consumer takes them.
module rrl_out_hold #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          ready,
  output logic          valid,
  output logic [DW-1:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= load_data;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rrl_rej_counter.sv
// Saturating count of discarded candidates, cleared per request.
module rrl_rej_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          bump,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (clear) begin
      count <= '0;
    end else if (bump && (count != '1)) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/rng_range_limiter.sv
module rng_range_limiter
  import rrl_pkg::*;
#(
  parameter int RAW_W = 16,
  parameter int REJ_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [RAW_W-1:0] limit_i,
  input  logic             raw_valid_i,
  input  logic [RAW_W-1:0] raw_data_i,
  output logic             raw_ready_o,
  output logic             res_valid_o,
  output logic [RAW_W-1:0] res_data_o,
  input  logic             res_ready_i,
  output logic [REJ_W-1:0] reject_cnt_o
);
  localparam int               DVS_W   = RAW_W + 1;
  localparam logic [RAW_W-1:0] RAW_MAX = '1;

  // A zero scale only arises for bound == RAW_MAX; a scale of 1 passes words through.
  function automatic logic [RAW_W-1:0] scale_floor_one(input logic [RAW_W-1:0] q);
    return (q == '0) ? RAW_W'(1) : q;
  endfunction

  function automatic logic beyond_bound(input logic [RAW_W-1:0] cand,
                                        input logic [RAW_W-1:0] bound);
    return cand > bound;
  endfunction

  function automatic logic [DVS_W-1:0] bound_plus_one(input logic [RAW_W-1:0] bound);
    return {1'b0, bound} + DVS_W'(1);
  endfunction

  rrl_state_e       st_q;
  logic [RAW_W-1:0] lim_q;
  logic [RAW_W-1:0] scale_q;

  logic             div_go;
  logic             div_done;
  logic [RAW_W-1:0] div_dvd;
  logic [DVS_W-1:0] div_dvs;
  logic [RAW_W-1:0] div_quo;

  // Named internal events, also used by the bound checker.
  logic ev_idle;
  logic ev_start;
  logic ev_fast;
  logic ev_take;
  logic ev_scaled;
  logic ev_reject;
  logic ev_keep;
  logic ev_emit;
  logic ev_retire;
  logic cand_over;

  assign ev_idle   = (st_q == ST_IDLE);
  assign ev_start  = ev_idle && start_i;
  assign ev_fast   = ev_start && (limit_i == '0);
  assign ev_take   = (st_q == ST_FETCH) && raw_valid_i;
  assign ev_scaled = (st_q == ST_SCALE) && div_done;
  assign cand_over = beyond_bound(div_quo, lim_q);
  assign ev_reject = (st_q == ST_DIV) && div_done && cand_over;
  assign ev_keep   = (st_q == ST_DIV) && div_done && !cand_over;
  assign ev_emit   = ev_fast || ev_keep;
  assign ev_retire = res_valid_o && res_ready_i;

  assign div_go  = (ev_start && !ev_fast) || ev_take;
  assign div_dvd = (st_q == ST_FETCH) ? raw_data_i : RAW_MAX;
  assign div_dvs = ev_idle ? bound_plus_one(limit_i) : {1'b0, scale_q};

  assign raw_ready_o = (st_q == ST_FETCH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      lim_q   <= '0;
      scale_q <= RAW_W'(1);
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (ev_start) begin
            lim_q <= limit_i;
            st_q  <= ev_fast ? ST_OFFER : ST_SCALE;
          end
        end
        ST_SCALE: begin
          if (ev_scaled) begin
            scale_q <= scale_floor_one(div_quo);
            st_q    <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (ev_take) st_q <= ST_DIV;
        end
        ST_DIV: begin
          if (ev_reject)    st_q <= ST_FETCH;
          else if (ev_keep) st_q <= ST_OFFER;
        end
        ST_OFFER: begin
          if (ev_retire) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  rrl_seq_div #(
    .DVD_W (RAW_W),
    .DVS_W (DVS_W)
  ) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (div_go),
    .dividend (div_dvd),
    .divisor  (div_dvs),
    .done     (div_done),
    .quotient (div_quo)
  );

  rrl_out_hold #(
    .DW (RAW_W)
  ) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ev_emit),
    .load_data (ev_fast ? '0 : div_quo),
    .ready     (res_ready_i),
    .valid     (res_valid_o),
    .data      (res_data_o)
  );

  rrl_rej_counter #(
    .CW (REJ_W)
  ) u_rej (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (ev_start),
    .bump  (ev_reject),
    .count (reject_cnt_o)
  );
endmodule

// File: rtl/rrl_chk.sv
module rrl_chk #(
  parameter int RAW_W = 16,
  parameter int REJ_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             ev_idle,
  input logic             ev_start,
  input logic             ev_fast,
  input logic             ev_reject,
  input logic [RAW_W-1:0] lim_q,
  input logic             raw_ready_o,
  input logic             res_valid_o,
  input logic [RAW_W-1:0] res_data_o,
  input logic             res_ready_i,
  input logic [REJ_W-1:0] reject_cnt_o
);
  p_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |-> (res_data_o <= lim_q));

  p_reject_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_reject && (reject_cnt_o != '1)) |=>
      (reject_cnt_o == REJ_W'($past(reject_cnt_o) + 1'b1)));

  p_zero_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fast |=> (res_valid_o && (res_data_o == '0)));

  p_hold_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && !res_ready_i) |=> (res_valid_o && $stable(res_data_o)));

  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && res_ready_i) |=> !res_valid_o);

  p_no_fetch_while_offer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    raw_ready_o |-> !res_valid_o);

  p_busy_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !ev_idle) |=> $stable(lim_q));

  p_count_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> (reject_cnt_o == '0));
endmodule

bind rng_range_limiter rrl_chk #(
  .RAW_W (RAW_W),
  .REJ_W (REJ_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .ev_idle      (ev_idle),
  .ev_start     (ev_start),
  .ev_fast      (ev_fast),
  .ev_reject    (ev_reject),
  .lim_q        (lim_q),
  .raw_ready_o  (raw_ready_o),
  .res_valid_o  (res_valid_o),
  .res_data_o   (res_data_o),
  .res_ready_i  (res_ready_i),
  .reject_cnt_o (reject_cnt_o)
);

// File: tb/rng_range_limiter_tb.sv
module rng_range_limiter_tb;
  localparam int W    = 16;
  localparam int RJ   = 8;
  localparam int RMAX = 65535;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [W-1:0]  limit;
  logic          raw_valid;
  logic [W-1:0]  raw_data;
  logic          raw_ready;
  logic          res_valid;
  logic [W-1:0]  res_data;
  logic          res_ready;
  logic [RJ-1:0] rej_cnt;

  always #5 clk = ~clk;

  rng_range_limiter #(.RAW_W(W), .REJ_W(RJ)) u_dut (
    .clk (clk), .rst_n (rst_n), .start_i (start), .limit_i (limit),
    .raw_valid_i (raw_valid), .raw_data_i (raw_data), .raw_ready_o (raw_ready),
    .res_valid_o (res_valid), .res_data_o (res_data), .res_ready_i (res_ready),
    .reject_cnt_o (rej_cnt)
  );

  // Raw word source: a ring of prepared words, advanced per handshake.
  logic [W-1:0] words [0:255];
  logic [7:0]   widx;
  logic         raw_en;
  logic         stall_mode;

  assign raw_valid = raw_en;
  assign raw_data  = words[widx];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) widx <= 8'd0;
    else if (raw_valid && raw_ready) widx <= widx + 8'd1;
  end

  always @(negedge clk) raw_en <= stall_mode ? (($urandom % 4) != 0) : 1'b1;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;
  bit done_flag = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000 && !done_flag) begin
      n_err = n_err + 1;
      $display("FAIL R3 watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int scale_of(input int lim);
    if (lim == RMAX) return 1;
    return RMAX / (lim + 1);
  endfunction

  // Walks the prepared words from base; returns expected result and discards.
  task automatic model(input int lim, input logic [7:0] base, output int res, output int nrej);
    int s;
    s = scale_of(lim);
    res = -1;
    nrej = 0;
    for (int i = 0; i < 32; i++) begin
      int q;
      q = int'(words[8'(base + i)]) / s;
      if (q <= lim) begin
        res = q;
        return;
      end
      nrej++;
    end
  endtask

  task automatic run_req(input int lim, input int nrej_force, input int hold_cyc,
                         input bit poke_busy, input int first_word);
    logic [7:0] base;
    int s, edge_lo, exp_res, exp_rej, guard;
    logic [W-1:0] held;
    base = widx;
    s = scale_of(lim);
    edge_lo = (lim + 1) * s;   // smallest raw word whose quotient exceeds lim
    for (int i = 0; i < 32; i++) begin
      int w;
      if (i < nrej_force && edge_lo <= RMAX) w = edge_lo + int'($urandom % (RMAX + 1 - edge_lo));
      else if (i == nrej_force)               w = int'($urandom % edge_lo);
      else                                    w = int'($urandom % (RMAX + 1));
      words[8'(base + i)] = W'(w);
    end
    if (first_word >= 0) words[base] = W'(first_word);
    model(lim, base, exp_res, exp_rej);
    if (lim == 0) begin
      exp_res = 0;
      exp_rej = 0;
    end

    @(negedge clk);
    limit = W'(lim);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (lim == 0) chk(res_valid == 1'b1 && res_data == '0, "R4 next-cycle zero", res_data, 0);
    if (poke_busy) begin
      limit = W'(lim == 0 ? 7 : lim - 1);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (!res_valid && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    chk(res_valid, "R3 result offered", res_valid, 1);
    held = res_data;
    for (int k = 0; k < hold_cyc; k++) begin
      @(negedge clk);
      chk(res_valid && res_data == held, "R6 held while stalled", res_data, held);
    end
    chk(res_data == W'(exp_res), poke_busy ? "R8 busy start ignored" : "R2 result value",
        res_data, exp_res);
    chk(int'(res_data) <= lim, "R1 within bound", res_data, lim);
    chk(int'(rej_cnt) == exp_rej, "R9 discard count", rej_cnt, exp_rej);
    chk(int'(8'(widx - base)) == (lim == 0 ? 0 : exp_rej + 1), "R7 words consumed",
        8'(widx - base), (lim == 0 ? 0 : exp_rej + 1));
    chk(!raw_ready, "R7 no fetch while offering", raw_ready, 0);
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk(!res_valid, "R6 released after ready", res_valid, 0);
  endtask

  initial begin
    stall_mode = 1'b0;
    rst_n = 1'b0;
    start = 1'b0;
    limit = '0;
    res_ready = 1'b0;
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) words[i] = '0;
    repeat (3) @(negedge clk);
    chk(!res_valid && !raw_ready && rej_cnt == '0, "R10 reset state",
        {res_valid, raw_ready, rej_cnt}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed corners
    run_req(2, 3, 0, 0, -1);          // R3 forced discards, small bound
    run_req(1, 5, 2, 0, 65535);       // R3 all-ones word rejected at bound 1
    run_req(0, 0, 3, 0, -1);          // R4 zero bound, stalled consumer
    run_req(RMAX, 0, 0, 0, -1);       // R5 full range: scale 1, word passes through
    chk(rej_cnt == '0, "R5 no discards at RAW_MAX", rej_cnt, 0);
    run_req(RMAX - 1, 2, 0, 0, -1);   // R2 scale 1, only 65535 rejected
    run_req(19, 4, 1, 1, -1);         // R8 start poked while busy
    run_req(19, 0, 0, 0, -1);         // R9 count cleared after busy request

    // Constrained random with a stalling source
    stall_mode = 1'b1;
    for (int n = 0; n < 40; n++) begin
      int lim;
      lim = (n % 3 == 0) ? int'($urandom % 16) : int'($urandom % (RMAX + 1));
      run_req(lim, int'($urandom % 6), int'($urandom % 3), (n % 7) == 3, -1);
    end

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule